// File: doc/BRIEF.md
# Capture-Based Phase Lock Detector

This block measures where the rising edge of a rectifier gate-drive signal falls inside one period of a current-zero-crossing sync square wave. A free-running counter restarts on each sync rising edge. The count at the first gate rising edge within the period is the offset. The count at the following sync rising edge is the period length. At the end of each period both counts are presented, and a multi-cycle restoring divider turns their ratio into a phase angle. The angle is a 16-bit unsigned value in units of 1/64 degree.

The finished phase is sorted into a lead/lag indication and a lock indication, and a one-cycle valid strobe marks each new result. A period is rejected as a measurement when it holds no gate edge, or when the counter reached its ceiling before the period closed. A rejected period raises a bad-measurement flag and drops lock. Both inputs pass through a synchronizer chain of equal depth, so that delay cancels out of the measurement. A period has to be longer than the divider's run of CNT_W+15 cycles, plus a few cycles of pipeline.

Top module: `phase_lock_detector`

## Requirements
- R1: After reset, every output is zero: captured counts, phase, lead flag, locked flag, bad flag and valid strobe.
- R2: When a period closes, `cap_gate_o` reports the number of clock cycles from the sync rising edge to the first gate rising edge of that period. A gate edge in the same cycle as the sync edge counts as 0. `cap_period_o` reports the number of cycles between the two sync rising edges.
- R3: Only the first gate rising edge in a period is captured. Later gate edges in the same period leave the offset unchanged.
- R4: For a good period, `phase_o` equals floor(23040 × offset / period). One LSB is 1/64 degree, and 23040 is a full turn.
- R5: `lead_o` is 1 when the phase is above 11520 (more than 180°) and 0 otherwise. Exactly 180° counts as lag.
- R6: `locked_o` is 1 when the phase is below 64 (under 1°) or above 22976 (over 359°). At exactly 64 or exactly 22976 it is 0.
- R7: A period with no gate rising edge produces a valid strobe with `meas_bad_o` = 1 and `locked_o` = 0, and `phase_o` keeps its previous value.
- R8: A period lasting 2^CNT_W − 1 cycles or more saturates the counter and is reported as bad, as in R7. A period of 2^CNT_W − 2 cycles is still measured normally.
- R9: `valid_o` is a single-cycle pulse, with one pulse for each closed period. The first sync edge after reset only starts counting and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Current zero-crossing sync square wave |
| gate_in | input | 1 | Rectifier gate-drive signal being measured |
| cap_gate_o | output | CNT_W | Offset count of the last closed period |
| cap_period_o | output | CNT_W | Length count of the last closed period |
| phase_o | output | 16 | Phase in 1/64 degree |
| lead_o | output | 1 | 1 = gate leads sync (phase above 180°) |
| locked_o | output | 1 | Phase within 1° of zero |
| meas_bad_o | output | 1 | Last period gave no measurement |
| valid_o | output | 1 | One-cycle strobe for a new result |

## Verification
The bench builds the detector with CNT_W = 10 and two synchronizer stages. The counter ceiling is then 1023 cycles, so both sides of the saturation boundary (periods of 1022 and 1023 cycles) fit within a short run, while the divider still needs 25 steps. Period lengths between 77 and 1000 cycles put the phase exactly on the 1°, 180° and 359° thresholds and also one count to either side of them. The runs also cover a gate edge that coincides with the sync edge and a period containing two gate edges.

// File: rtl/pld_pkg.sv
package pld_pkg;
  localparam int PHASE_W = 16;
  // phase units: 1/64 degree
  localparam logic [PHASE_W-1:0] FULL_TURN = 16'd23040;
  localparam logic [PHASE_W-1:0] HALF_TURN = 16'd11520;
  localparam logic [PHASE_W-1:0] LOCK_TOL  = 16'd64;

  function automatic logic phase_is_lead(logic [PHASE_W-1:0] p);
    return p > HALF_TURN;
  endfunction

  function automatic logic phase_is_locked(logic [PHASE_W-1:0] p);
    return (p < LOCK_TOL) || (p > (FULL_TURN - LOCK_TOL));
  endfunction
endpackage

// File: rtl/pld_edge.sv
module pld_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise
);
  logic [STAGES-1:0] sh;
  logic              last;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) sh[0] <= 1'b0;
        else        sh[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) sh[i] <= 1'b0;
        else        sh[i] <= sh[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last <= 1'b0;
    else        last <= sh[STAGES-1];
  end

  assign rise = sh[STAGES-1] & ~last;
endmodule

// File: rtl/pld_capture.sv
module pld_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_rise,
  input  logic             gate_rise,
  output logic [CNT_W-1:0] cap_gate,
  output logic [CNT_W-1:0] cap_period,
  output logic             go,
  output logic             bad
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] run_gate;
  logic             gate_seen;
  logic             armed;
  logic             at_max;
  logic             first_gate;

  assign at_max     = (cnt == CNT_MAX);
  assign first_gate = gate_rise & ~gate_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      run_gate   <= '0;
      gate_seen  <= 1'b0;
      armed      <= 1'b0;
      cap_gate   <= '0;
      cap_period <= '0;
      go         <= 1'b0;
      bad        <= 1'b0;
    end else begin
      go  <= 1'b0;
      bad <= 1'b0;
      if (sync_rise) begin
        cnt   <= CNT_W'(1);
        armed <= 1'b1;
        if (armed) begin
          cap_gate   <= run_gate;
          cap_period <= cnt;
          go         <= gate_seen & ~at_max;
          bad        <= ~gate_seen | at_max;
        end
        gate_seen <= gate_rise;
        run_gate  <= '0;
      end else begin
        if (!at_max) cnt <= cnt + CNT_W'(1);
        if (first_gate) begin
          gate_seen <= 1'b1;
          run_gate  <= cnt;
        end
      end
    end
  end

  assert_cnt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (at_max && !sync_rise) |=> at_max);
  assert_gate_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_seen && !sync_rise) |=> $stable(run_gate));
  assert_first_arms_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_rise && !armed) |=> (!go && !bad));
  assert_go_bad_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(go && bad));
endmodule

// File: rtl/pld_divider.sv
module pld_divider #(
  parameter int NUM_W = 31,
  parameter int DEN_W = 16,
  parameter int Q_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [Q_W-1:0]   quot
);
  localparam int STEP_W = $clog2(NUM_W);

  logic [DEN_W:0]    rem;
  logic [NUM_W-1:0]  nsh;
  logic [NUM_W-1:0]  q;
  logic [DEN_W-1:0]  den_r;
  logic [STEP_W-1:0] step;
  logic [DEN_W:0]    shifted;
  logic [DEN_W+1:0]  diff;
  logic              borrow;

  assign shifted = {rem[DEN_W-1:0], nsh[NUM_W-1]};
  assign diff    = {1'b0, shifted} - {2'b00, den_r};
  assign borrow  = diff[DEN_W+1];
  assign quot    = q[Q_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem   <= '0;
      nsh   <= '0;
      q     <= '0;
      den_r <= '0;
      step  <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        rem   <= '0;
        nsh   <= num;
        q     <= '0;
        den_r <= den;
        step  <= '0;
        busy  <= 1'b1;
      end else if (busy) begin
        rem  <= borrow ? shifted : diff[DEN_W:0];
        nsh  <= {nsh[NUM_W-2:0], 1'b0};
        q    <= {q[NUM_W-2:0], ~borrow};
        step <= step + STEP_W'(1);
        if (step == STEP_W'(NUM_W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assert_quot_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (q[NUM_W-1:Q_W] == '0));
  assert_rem_below_den_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rem < {1'b0, den_r}));
endmodule

// File: rtl/phase_lock_detector.sv
module phase_lock_detector #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sync_in,
  input  logic                         gate_in,
  output logic [CNT_W-1:0]             cap_gate_o,
  output logic [CNT_W-1:0]             cap_period_o,
  output logic [pld_pkg::PHASE_W-1:0]  phase_o,
  output logic                         lead_o,
  output logic                         locked_o,
  output logic                         meas_bad_o,
  output logic                         valid_o
);
  import pld_pkg::*;

  localparam int NUM_W = CNT_W + 15;

  logic                 sync_rise;
  logic                 gate_rise;
  logic                 div_go;
  logic                 period_bad;
  logic                 div_busy;
  logic                 div_done;
  logic [NUM_W-1:0]     div_num;
  logic [PHASE_W-1:0]   div_quot;

  pld_edge #(.STAGES(SYNC_STAGES)) u_sync_edge (
    .clk(clk), .rst_n(rst_n), .d(sync_in), .rise(sync_rise));
  pld_edge #(.STAGES(SYNC_STAGES)) u_gate_edge (
    .clk(clk), .rst_n(rst_n), .d(gate_in), .rise(gate_rise));

  pld_capture #(.CNT_W(CNT_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .sync_rise(sync_rise), .gate_rise(gate_rise),
    .cap_gate(cap_gate_o), .cap_period(cap_period_o),
    .go(div_go), .bad(period_bad));

  assign div_num = NUM_W'(cap_gate_o) * NUM_W'(FULL_TURN);

  pld_divider #(.NUM_W(NUM_W), .DEN_W(CNT_W), .Q_W(PHASE_W)) u_divider (
    .clk(clk), .rst_n(rst_n), .start(div_go), .num(div_num), .den(cap_period_o),
    .busy(div_busy), .done(div_done), .quot(div_quot));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_o    <= '0;
      lead_o     <= 1'b0;
      locked_o   <= 1'b0;
      meas_bad_o <= 1'b0;
      valid_o    <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (div_done) begin
        phase_o    <= div_quot;
        lead_o     <= phase_is_lead(div_quot);
        locked_o   <= phase_is_locked(div_quot);
        meas_bad_o <= 1'b0;
        valid_o    <= 1'b1;
      end else if (period_bad) begin
        locked_o   <= 1'b0;
        meas_bad_o <= 1'b1;
        valid_o    <= 1'b1;
      end
    end
  end

  assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  assert_div_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |=> (valid_o && !meas_bad_o));
  assert_div_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (div_go && !div_busy) |=> div_busy);
  assert_phase_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !meas_bad_o) |-> (phase_o < FULL_TURN));
  assert_cap_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !meas_bad_o) |-> (cap_gate_o < cap_period_o));
  assert_bad_unlocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && meas_bad_o) |-> !locked_o);
endmodule

// File: tb/test_phase_lock_detector.sv
module test_phase_lock_detector;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 10;
  localparam int NV         = 11;
  localparam int VP [NV] = '{100, 100, 100, 100, 100, 400, 400, 360, 360, 77, 1000};
  localparam int VK [NV] = '{0,   25,  50,  51,  99,  399, 1,   1,   359, 30, 500};

  logic             clk = 1'b0;
  logic             rst_n;
  logic             sync_in;
  logic             gate_in;
  logic [CNT_W-1:0] cap_gate_o;
  logic [CNT_W-1:0] cap_period_o;
  logic [15:0]      phase_o;
  logic             lead_o, locked_o, meas_bad_o, valid_o;

  int nchk = 0;
  int nfail = 0;
  int vcount = 0;
  int l_gate, l_period, l_phase, l_lead, l_lock, l_bad;
  bit finished = 0;

  phase_lock_detector #(.CNT_W(CNT_W), .SYNC_STAGES(2)) i_phase_lock_detector (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .gate_in(gate_in),
    .cap_gate_o(cap_gate_o), .cap_period_o(cap_period_o), .phase_o(phase_o),
    .lead_o(lead_o), .locked_o(locked_o), .meas_bad_o(meas_bad_o), .valid_o(valid_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (valid_o) begin
      vcount++;
      l_gate = int'(cap_gate_o); l_period = int'(cap_period_o);
      l_phase = int'(phase_o); l_lead = int'(lead_o);
      l_lock = int'(locked_o); l_bad = int'(meas_bad_o);
    end
  end

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_period(int p, int k1, int k2);
    for (int c = 0; c < p; c++) begin
      @(negedge clk);
      sync_in = (c == 0);
      gate_in = (c == k1) || (c == k2);
    end
  endtask

  task automatic close_and_wait();
    @(negedge clk); sync_in = 1'b1; gate_in = 1'b0;
    @(negedge clk); sync_in = 1'b0;
    repeat (60) @(negedge clk);
  endtask

  // expected values come from the requirement formulas
  task automatic check_good(int p, int k1, int k2);
    int vc0;
    int ep;
    run_period(p, k1, k2);
    run_period(p, k1, k2);
    vc0 = vcount;
    close_and_wait();
    ep = (k1 * 23040) / p;
    chk("R9 one strobe", vcount, vc0 + 1);
    chk("R2 offset", l_gate, k1);
    chk("R2 period", l_period, p);
    chk("R7 bad flag clear", l_bad, 0);
    chk("R4 phase", l_phase, ep);
    chk("R5 lead", l_lead, (ep > 11520) ? 1 : 0);
    chk("R6 locked", l_lock, ((ep < 64) || (ep > 22976)) ? 1 : 0);
  endtask

  task automatic check_bad(string tag, int p, int k1, int prev_phase);
    int vc0;
    run_period(p, k1, -1);
    vc0 = vcount;
    close_and_wait();
    chk({tag, " strobe"}, vcount, vc0 + 1);
    chk({tag, " bad flag"}, l_bad, 1);
    chk({tag, " lock dropped"}, l_lock, 0);
    chk({tag, " phase held"}, l_phase, prev_phase);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL R9 watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sync_in = 1'b0; gate_in = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 cap_gate", int'(cap_gate_o), 0);
    chk("R1 cap_period", int'(cap_period_o), 0);
    chk("R1 phase", int'(phase_o), 0);
    chk("R1 lead", int'(lead_o), 0);
    chk("R1 locked", int'(locked_o), 0);
    chk("R1 bad", int'(meas_bad_o), 0);
    chk("R1 valid", int'(valid_o), 0);

    // R9: first sync edge only arms
    close_and_wait();
    chk("R9 no strobe on first edge", vcount, 0);

    for (int v = 0; v < NV; v++) check_good(VP[v], VK[v], -1);

    // R3: second gate edge in a period is ignored
    check_good(100, 20, 60);

    // R7: missing gate edge after a locked result (phase 57 held)
    check_good(400, 1, -1);
    check_bad("R7", 100, -1, (23040 * 1) / 400);

    // R8: saturation boundary
    check_bad("R8 at ceiling", 1023, 10, (23040 * 1) / 400);
    check_good(1022, 10, -1);
    check_bad("R8 beyond ceiling", 1500, 10, (23040 * 10) / 1022);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule